// File: doc/BRIEF.md
# Coprocessor interrupt request logic

This block holds the pending-interrupt bits of a coprocessor cause register and turns them into one hard-interrupt request for the processor core. Level-sensitive line events, a timer-match pulse and a compare-write pulse update the pending bits. A status register holds a per-line mask, a global enable and two exception-state flags. A debug-mode input from the core also blocks the request. The request output is registered, and it is evaluated again on every edge from the next-state values. It rises one cycle after a cause becomes active and falls one cycle after the cause goes away.

Software accesses the status and cause words through a simple register port with one select bit. Writes to cause reach only the two software-interrupt bits. All other pending bits belong to hardware. An interrupt controller is expected on line 2. The timer always uses line 7.

Top module: `cop_irq_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, the global enable is 0, the error flag is 1, the exception flag is 0, the mask is 0, and `irq_o` is 0.
- R2: A line event with index n below 16 sets pending bit n (cause word bit 8+n) when `line_lvl_i` is 1 and clears it when `line_lvl_i` is 0.
- R3: A line event with an index of 16 or more changes no state.
- R4: A pulse on `tmr_match_i` sets pending bit 7 (cause word bit 15).
- R5: A pulse on `cmp_wr_i` clears pending bit 7. When a match arrives in the same cycle, the match wins.
- R6: A write to cause (`reg_sel_i`=1) changes only pending bits 0 and 1, taken from write-data bits 8 and 9. If a line event for the same bit arrives in that cycle, the event wins.
- R7: `irq_o` is 1 exactly when, after the previous edge, (mask AND pending[7:0]) is nonzero, the enable is 1, the exception and error flags are 0, and `dbg_mode_i` was 0 at that edge. The output has one cycle of latency.
- R8: `irq_o` falls in the cycle after its cause, mask bit or gating condition goes away. It is never held latched.
- R9: A status write (`reg_sel_i`=0) loads the enable from bit 0, the exception flag from bit 1, the error flag from bit 2 and the mask from bits 15:8. All other status bits read as 0.
- R10: `reg_rdata_o` is registered. After each edge it shows the word selected by `reg_sel_i` as that word stood before the edge. The cause word carries the pending bits at bits 23:8 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_vld_i | input | 1 | Line level event valid |
| line_idx_i | input | 5 | Line index of the event |
| line_lvl_i | input | 1 | New level of the line |
| tmr_match_i | input | 1 | Timer match pulse |
| cmp_wr_i | input | 1 | Compare register write pulse |
| dbg_mode_i | input | 1 | Core is in debug mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status, 1 selects cause |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered hard-interrupt request |

## Verification
The hardest cases to reach from the ports are conflicts inside a single cycle. One is a timer match arriving with a compare write. Another is a software cause write arriving with a line event for the same bit. The driver applies both pulses on the same falling edge, and the scoreboard checks which source won at the following edge. Masked pending bits and lines above the masked field are also driven while the request is enabled, to show that they never raise the request. The gating flags and debug mode are toggled while a source stays active, to show that the request falls and rises again without being held latched.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int IP_W      = 8;
  localparam int PEND_LSB  = 8;
  localparam int ST_IE     = 0;
  localparam int ST_EXC    = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_MASK   = 8;

  typedef struct packed {
    logic [IP_W-1:0] mask;
    logic            err;
    logic            exc;
    logic            ie;
  } stat_t;

  typedef enum logic {
    SEL_STAT  = 1'b0,
    SEL_CAUSE = 1'b1
  } sel_e;
endpackage

// File: rtl/cop_irq_pend.sv
module cop_irq_pend #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 5,
  parameter int TMR_LINE  = 7,
  parameter int SW_LINES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_vld,
  input  logic [IDX_W-1:0]     ev_idx,
  input  logic                 ev_lvl,
  input  logic                 tmr_match,
  input  logic                 cmp_wr,
  input  logic                 sw_we,
  input  logic [SW_LINES-1:0]  sw_bits,
  output logic [NUM_LINES-1:0] pend_d,
  output logic [NUM_LINES-1:0] pend_q
);
  logic [NUM_LINES-1:0] sw_en, sw_val;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    localparam logic IS_TMR = (i == TMR_LINE);
    logic nxt;

    if (i < SW_LINES) begin : g_sw
      assign sw_en[i]  = sw_we;
      assign sw_val[i] = sw_bits[i];
    end else begin : g_hw
      assign sw_en[i]  = 1'b0;
      assign sw_val[i] = 1'b0;
    end

    always_comb begin
      nxt = pend_q[i];
      if (sw_en[i]) nxt = sw_val[i];
      if (ev_vld && (int'(ev_idx) == i)) nxt = ev_lvl;
      if (IS_TMR && cmp_wr) nxt = 1'b0;
      if (IS_TMR && tmr_match) nxt = 1'b1;
    end
    assign pend_d[i] = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  AST_BAD_LINE_NOCHG: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && int'(ev_idx) >= NUM_LINES && !tmr_match && !cmp_wr && !sw_we)
      |=> $stable(pend_q)); // R3
  AST_TMR_SET: assert property (@(posedge clk) disable iff (rst)
    tmr_match |=> pend_q[TMR_LINE]); // R4
  AST_CMP_CLR: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && !tmr_match) |=> !pend_q[TMR_LINE]); // R5
  AST_SW_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !ev_vld && !tmr_match && !cmp_wr)
      |=> pend_q[NUM_LINES-1:SW_LINES] == $past(pend_q[NUM_LINES-1:SW_LINES])); // R6
endmodule

// File: rtl/cop_irq_stat.sv
module cop_irq_stat
  import cop_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output stat_t             stat_d,
  output stat_t             stat_q
);
  always_comb begin
    stat_d = stat_q;
    if (we) begin
      stat_d.ie   = wdata[ST_IE];
      stat_d.exc  = wdata[ST_EXC];
      stat_d.err  = wdata[ST_ERR];
      stat_d.mask = wdata[ST_MASK +: IP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q      <= '0;
      stat_q.err  <= 1'b1;
    end else begin
      stat_q <= stat_d;
    end
  end

  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (stat_q.ie == $past(wdata[ST_IE]) && stat_q.mask == $past(wdata[ST_MASK +: IP_W]))); // R9
endmodule

// File: rtl/cop_irq_req.sv
module cop_irq_req
  import cop_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [IP_W-1:0] ip_nxt,
  input  stat_t           stat_nxt,
  input  logic            dbg,
  output logic            irq
);
  logic hit, open_gate;

  assign hit       = |(ip_nxt & stat_nxt.mask);
  assign open_gate = stat_nxt.ie && !stat_nxt.exc && !stat_nxt.err && !dbg;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= hit && open_gate;
  end
endmodule

// File: rtl/cop_irq_ctrl.sv
module cop_irq_ctrl
  import cop_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 5,
  parameter int TMR_LINE  = 7,
  parameter int SW_LINES  = 2,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_vld_i,
  input  logic [IDX_W-1:0]  line_idx_i,
  input  logic              line_lvl_i,
  input  logic              tmr_match_i,
  input  logic              cmp_wr_i,
  input  logic              dbg_mode_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_LINES-1:0] pend_d, pend_q;
  stat_t                stat_d, stat_q;
  logic                 cause_we, stat_we;
  logic [DATA_W-1:0]    cause_w, stat_w, rd_q;

  assign cause_we = reg_we_i && (sel_e'(reg_sel_i) == SEL_CAUSE);
  assign stat_we  = reg_we_i && (sel_e'(reg_sel_i) == SEL_STAT);

  cop_irq_pend #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TMR_LINE(TMR_LINE), .SW_LINES(SW_LINES)
  ) u_pend (
    .clk(clk), .rst(rst),
    .ev_vld(line_vld_i), .ev_idx(line_idx_i), .ev_lvl(line_lvl_i),
    .tmr_match(tmr_match_i), .cmp_wr(cmp_wr_i),
    .sw_we(cause_we), .sw_bits(reg_wdata_i[PEND_LSB +: SW_LINES]),
    .pend_d(pend_d), .pend_q(pend_q)
  );

  cop_irq_stat #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .we(stat_we), .wdata(reg_wdata_i),
    .stat_d(stat_d), .stat_q(stat_q)
  );

  cop_irq_req u_req (
    .clk(clk), .rst(rst), .ip_nxt(pend_d[IP_W-1:0]), .stat_nxt(stat_d),
    .dbg(dbg_mode_i), .irq(irq_o)
  );

  always_comb begin
    cause_w = '0;
    cause_w[PEND_LSB +: NUM_LINES] = pend_q;
    stat_w = '0;
    stat_w[ST_IE]  = stat_q.ie;
    stat_w[ST_EXC] = stat_q.exc;
    stat_w[ST_ERR] = stat_q.err;
    stat_w[ST_MASK +: IP_W] = stat_q.mask;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= (sel_e'(reg_sel_i) == SEL_CAUSE) ? cause_w : stat_w;
  end
  assign reg_rdata_o = rd_q;

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((|(stat_q.mask & pend_q[IP_W-1:0])) && stat_q.ie && !stat_q.exc
               && !stat_q.err && !$past(dbg_mode_i))); // R7
  AST_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    !((|(stat_q.mask & pend_q[IP_W-1:0])) && stat_q.ie && !stat_q.exc && !stat_q.err)
      |-> !irq_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !irq_o); // R1
endmodule

// File: tb/cop_irq_ctrl_tb.sv
module cop_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_vld_i = 0, line_lvl_i = 0, tmr_match_i = 0, cmp_wr_i = 0;
  logic        dbg_mode_i = 0, reg_we_i = 0, reg_sel_i = 0;
  logic [4:0]  line_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        irq;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_pend = '0;
  logic [7:0]  m_mask = '0;
  logic        m_ie = 0, m_exc = 0, m_err = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .line_vld_i(line_vld_i), .line_idx_i(line_idx_i),
    .line_lvl_i(line_lvl_i), .tmr_match_i(tmr_match_i), .cmp_wr_i(cmp_wr_i),
    .dbg_mode_i(dbg_mode_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] stat_word();
    return {16'h0, m_mask, 5'b0, m_err, m_exc, m_ie};
  endfunction

  function automatic logic [31:0] cause_word();
    return {8'h0, m_pend, 8'h0};
  endfunction

  task automatic step(input logic vld, input logic [4:0] idx, input logic lvl,
                      input logic match, input logic cmpw, input logic dbg,
                      input logic we, input logic sel, input logic [31:0] wd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    line_vld_i = vld; line_idx_i = idx; line_lvl_i = lvl;
    tmr_match_i = match; cmp_wr_i = cmpw; dbg_mode_i = dbg;
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
    e.rd  = sel ? cause_word() : stat_word();
    e.tag = tag;
    if (we && !sel) begin
      m_ie = wd[0]; m_exc = wd[1]; m_err = wd[2]; m_mask = wd[15:8];
    end
    if (we && sel) m_pend[1:0] = wd[9:8];
    if (vld && idx < 5'd16) m_pend[idx[3:0]] = lvl;
    if (cmpw)  m_pend[7] = 1'b0;
    if (match) m_pend[7] = 1'b1;
    e.irq = (|(m_mask & m_pend[7:0])) && m_ie && !m_exc && !m_err && !dbg;
    sb.push_back(e);
  endtask

  task automatic idle_read(input logic sel, input string tag);
    step(0, 5'd0, 0, 0, 0, 0, 0, sel, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (irq_o !== e.irq) begin
        errors++;
        $display("FAIL %s irq_o: actual %0b expected %0b", e.tag, irq_o, e.irq);
      end
      checks++;
      if (reg_rdata_o !== e.rd) begin
        errors++;
        $display("FAIL %s reg_rdata_o: actual %08h expected %08h", e.tag, reg_rdata_o, e.rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset values of status, cause and request
    idle_read(0, "R1");
    idle_read(1, "R1");
    // R9 open the gate, mask lines 2 and 7
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_8401, "R9");
    idle_read(0, "R9");
    // R2 R7 controller line 2 raises the request
    step(1, 5'd2, 1, 0, 0, 0, 0, 1, 32'h0, "R7");
    idle_read(1, "R2");
    // R8 line 2 drops, request follows
    step(1, 5'd2, 0, 0, 0, 0, 0, 1, 32'h0, "R8");
    idle_read(1, "R8");
    // R2 masked line 3 sets pending without a request
    step(1, 5'd3, 1, 0, 0, 0, 0, 1, 32'h0, "R2");
    idle_read(1, "R2");
    // R3 out-of-range indices ignored
    step(1, 5'd20, 1, 0, 0, 0, 0, 1, 32'h0, "R3");
    step(1, 5'd31, 1, 0, 0, 0, 0, 1, 32'h0, "R3");
    idle_read(1, "R3");
    // R4 timer match
    step(0, 5'd0, 0, 1, 0, 0, 0, 1, 32'h0, "R4");
    idle_read(1, "R4");
    // R5 compare write clears, then same-cycle match wins
    step(0, 5'd0, 0, 0, 1, 0, 0, 1, 32'h0, "R5");
    idle_read(1, "R5");
    step(0, 5'd0, 0, 1, 1, 0, 0, 1, 32'h0, "R5");
    idle_read(1, "R5");
    // R7 R8 gating by debug, exception and error flags
    step(0, 5'd0, 0, 0, 0, 1, 0, 0, 32'h0, "R7");
    idle_read(0, "R8");
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_8403, "R8");
    idle_read(0, "R7");
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_8405, "R8");
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_8401, "R7");
    // R5 clear timer, request falls
    step(0, 5'd0, 0, 0, 1, 0, 0, 1, 32'h0, "R8");
    // R6 software write touches only the two low lines
    step(0, 5'd0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, "R6");
    idle_read(1, "R6");
    // R7 mask change alone raises the request on software line 0
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_8501, "R7");
    // R6 line event beats software write on bit 1
    step(1, 5'd1, 0, 0, 0, 0, 1, 1, 32'h0000_0300, "R6");
    idle_read(1, "R6");
    step(0, 5'd0, 0, 0, 0, 0, 1, 1, 32'h0, "R8");
    // R2 line above the masked field sets pending but never requests
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'h0000_FF01, "R9");
    step(1, 5'd12, 1, 0, 0, 0, 0, 1, 32'h0, "R2");
    step(1, 5'd11, 0, 0, 0, 0, 0, 1, 32'h0, "R2");
    idle_read(1, "R10");
    // R9 reserved status bits read zero
    step(0, 5'd0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R9");
    idle_read(0, "R9");
    idle_read(0, "R10");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule